// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block takes a single-wire serial stream in which every rising clock edge carries exactly one bit. It needs no baud timing and does no oversampling. The line rests high. A low level seen while the receiver is idle marks the start of a frame. The receiver then collects eight data bits, least significant first. It reads a parity bit and then a stop bit. On the cycle after the stop bit it reports the outcome on two strobes. The valid strobe means the frame was good. The error strobe means the parity or the stop bit was wrong.

The assembled byte is loaded onto the parallel output at the end of every frame, good or bad. It stays there until the next frame ends. The receiver is back in idle on the cycle after the stop bit. A new start bit may follow at once, so frames can run back to back with no gap.

Top module: `serial_byte_rx`

## Requirements
- R1: While the receiver is idle and the line is high (1), no frame begins and neither strobe is raised.
- R2: A frame is one low start bit, then eight data bits with the least significant bit first, then a parity bit and a stop bit. Each bit occupies one clock cycle. The data bits are assembled into the byte in their order of arrival, bit 0 first.
- R3: `rx_valid` and `rx_err` are low while the start bit, the data bits and the parity bit are being received.
- R4: One of the two strobes is high in the cycle after the clock edge that samples the stop bit. In that same cycle `rx_byte` shows the received byte.
- R5: The byte 0x6E followed by a parity bit of 1 and a stop bit of 1 is accepted: `rx_valid` is 1, `rx_err` is 0 and `rx_byte` is 0x6E.
- R6: Parity is even. If the eight data bits and the parity bit together hold an odd number of ones, `rx_err` is raised and `rx_valid` stays low.
- R7: A stop bit sampled low (0) raises `rx_err`, and `rx_valid` stays low. The two strobes are never high together.
- R8: Each strobe lasts exactly one cycle. A start bit placed on the line directly after the stop bit begins a new frame.
- R9: `rx_byte` keeps its value between frame ends. It is reloaded at the end of every frame, including frames that end in an error.
- R10: The synchronous, active-high reset `rst` returns the receiver to idle, clears both strobes and clears `rx_byte` to 0. A reset in the middle of a frame abandons that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit is sampled on each rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sin | input | 1 | Serial line, high when idle |
| rx_byte | output | DATA_W (8) | Byte from the most recent completed frame |
| rx_valid | output | 1 | One-cycle strobe: the frame was good |
| rx_err | output | 1 | One-cycle strobe: parity or stop bit failure |

## Verification
The hardest situation to reach from the ports is a stop bit that is followed directly by a new start bit, so that the strobe of one frame overlaps the first sampled bit of the next. The stimulus sends frames back to back with no idle cycle between them, including right after a frame that failed. It also resets in the middle of a frame. A behavioural model tracks the bit position on every cycle, so any drift in frame alignment shows up at the next strobe.

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sin,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              rx_err
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic [CNT_W-1:0] idx;
  logic [DATA_W-1:0] shreg;
  logic             odd;
  logic             par_bad;

  wire last_bit = (idx == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      idx      <= '0;
      shreg    <= '0;
      odd      <= 1'b0;
      par_bad  <= 1'b0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      unique case (st)
        S_IDLE: if (!sin) begin
          st  <= S_DATA;
          idx <= '0;
          odd <= 1'b0;
        end
        S_DATA: begin
          shreg <= {sin, shreg[DATA_W-1:1]};
          odd   <= odd ^ sin;
          idx   <= idx + 1'b1;
          if (last_bit) st <= S_PAR;
        end
        S_PAR: begin
          par_bad <= odd ^ sin;
          st      <= S_STOP;
        end
        S_STOP: begin
          rx_byte  <= shreg;
          rx_valid <= ~par_bad & sin;
          rx_err   <= par_bad | ~sin;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (st == S_IDLE && !rx_valid && !rx_err && rx_byte == '0));

  p_line_high_r1: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && sin) |=> (st == S_IDLE));

  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA || st == S_PAR) |-> (!rx_valid && !rx_err));

  p_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_STOP) |=> (st == S_IDLE && (rx_valid || rx_err)));

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_err));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> !rx_err);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st != S_STOP) |=> $stable(rx_byte));

endmodule

// File: tb/sim_serial_byte_rx.sv
module sim_serial_byte_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sin = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       rx_err;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R10";

  // behavioural reference state
  int       ph = -1;
  int       ones = 0;
  bit [7:0] acc = 0;
  bit [7:0] m_byte = 0;
  bit       m_valid = 0;
  bit       m_err = 0;

  serial_byte_rx #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .sin(sin),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    started = 1;
    cycles++;
    if (rst) begin
      ph = -1; m_byte = 0; m_valid = 0; m_err = 0;
    end else begin
      m_valid = 0;
      m_err = 0;
      if (ph == -1) begin
        if (sin == 1'b0) begin ph = 0; ones = 0; acc = 0; end
      end else if (ph < 8) begin
        acc[ph] = sin;
        ones += int'(sin);
        ph++;
      end else if (ph == 8) begin
        ones += int'(sin);
        ph = 9;
      end else begin
        if ((ones % 2) == 0 && sin) m_valid = 1;
        else m_err = 1;
        m_byte = acc;
        ph = -1;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (rx_valid !== m_valid || rx_err !== m_err || rx_byte !== m_byte) begin
        fails++;
        $display("FAIL %s: got valid=%b err=%b byte=%02h, expected valid=%b err=%b byte=%02h",
                 cur_req, rx_valid, rx_err, rx_byte, m_valid, m_err, m_byte);
      end
    end
  end

  task automatic put(input bit b);
    @(negedge clk);
    sin = b;
  endtask

  task automatic frame(input bit [7:0] d, input bit bad_par, input bit stop);
    put(1'b0);
    for (int i = 0; i < 8; i++) put(d[i]);
    put((^d) ^ bad_par);
    put(stop);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b1);
  endtask

  initial begin
    cur_req = "R10";
    rst = 1'b1;
    idle(3);
    @(negedge clk); rst = 1'b0;

    cur_req = "R1";
    idle(6);

    cur_req = "R5";
    frame(8'h6E, 1'b0, 1'b1);
    idle(2);

    cur_req = "R2";
    frame(8'h00, 1'b0, 1'b1);
    frame(8'hFF, 1'b0, 1'b1);
    idle(1);
    frame(8'h01, 1'b0, 1'b1);
    idle(1);
    frame(8'h80, 1'b0, 1'b1);
    idle(1);
    frame(8'hA5, 1'b0, 1'b1);
    idle(3);

    cur_req = "R6";
    frame(8'h3C, 1'b1, 1'b1);
    idle(2);
    frame(8'h01, 1'b1, 1'b1);
    idle(2);

    cur_req = "R7";
    frame(8'h5A, 1'b0, 1'b0);
    idle(2);
    frame(8'hC3, 1'b1, 1'b0);
    idle(2);

    cur_req = "R8";
    frame(8'h12, 1'b0, 1'b1);
    frame(8'h34, 1'b1, 1'b1);
    frame(8'h56, 1'b0, 1'b1);
    idle(2);

    cur_req = "R9";
    frame(8'h9D, 1'b0, 1'b1);
    idle(10);
    frame(8'h4B, 1'b1, 1'b1);
    idle(5);

    cur_req = "R10";
    put(1'b0); put(1'b1); put(1'b0); put(1'b1);
    @(negedge clk); rst = 1'b1; sin = 1'b1;
    @(negedge clk); rst = 1'b0;
    idle(4);
    frame(8'h6E, 1'b0, 1'b1);
    idle(2);

    cur_req = "R3";
    for (int i = 0; i < 40; i++) begin
      frame(8'((i * 37 + 11) & 255), (i % 5) == 3, (i % 7) != 4);
      if (i % 3 == 0) idle(i % 4);
    end
    idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule